// File: doc/BRIEF.md
# Six-Channel Lead-In PWM Controller

This block generates six independent pulse-width-modulated outputs and is programmed through a word-addressed register port. Each channel owns a control word and a timing word. The control word holds an enable flag, a lead-in delay and a repeat count. The timing word holds the lengths of the high and low phases, measured in clock cycles. Each output is active-high: it is high for the high count and then low for the low count.

When a channel is enabled, it first holds its output low for the lead-in delay. It then runs periods. It runs them forever if the repeat count is zero. Otherwise it runs exactly that many periods and then parks with its output low. Clearing the enable flag drops the output at once and abandons the period in progress. A new timing word written while the channel runs is held back until the current period ends.

Each channel is a five-state machine:
- IDLE: waiting for the enable flag.
- LEAD: lead-in delay.
- HIGH: high phase.
- LOW: low phase.
- DONE: the finite run is finished.

Its transitions are:
- IDLE→LEAD when enabled with a nonzero lead-in.
- IDLE→HIGH or IDLE→LOW when enabled with no lead-in.
- LEAD→HIGH or LEAD→LOW when the lead-in expires.
- HIGH→LOW at the end of the high phase.
- HIGH→HIGH, LOW→HIGH or LOW→LOW at a period boundary, when the next period starts.
- HIGH→DONE or LOW→DONE when the last counted period ends.
- Any state→IDLE when the enable flag is clear.

Top module: `pwm_leadin_ctrl`

## Requirements
- R1: The six channels run independently. Channel c drives pwm_out[c], and programming one channel never changes another channel's output.
- R2: Word address c (0..5) selects the control word of channel c, and word address 8+c selects its timing word. Writes to addresses 6, 7, 14 and 15 change nothing, and reads of those addresses return zero.
- R3: Control word layout: bit 31 is the enable flag, bits 30:16 are the lead-in length in cycles, and bits 15:0 are the repeat count.
- R4: Timing word layout: bits 31:16 are the high count and bits 15:0 are the low count. A period is the high count of cycles with the output high, followed by the low count of cycles with the output low.
- R5: The enable write takes effect at clock edge E. With lead-in L, the output is low in the cycle after E and in the L cycles that follow. The first period starts in the cycle after edge E+L+1 and uses the timing word held at that moment.
- R6: A repeat count of 0 makes the channel repeat periods without end.
- R7: A repeat count of N>0 gives exactly N periods, after which the output stays low. The enable flag still reads back as 1, and the channel does not restart until the flag is cleared and set again.
- R8: A write that clears the enable flag forces the output low in the very next cycle. A later enable restarts the sequence from the lead-in.
- R9: A timing word written while a channel runs leaves the current period unchanged. The first period that starts after that write uses the new value.
- R10: A high count of 0 gives a steady low output. A low count of 0 gives a steady high output while running. When both counts are 0, the output stays low, and each such period lasts one cycle for repeat counting.
- R11: Every mapped register reads back the last value written to it. After reset, all registers read zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Word address of the register accessed |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 32 | Data written to the addressed register |
| rd_data | output | 32 | Combinational read of the addressed register |
| pwm_out | output | 6 | One PWM output per channel |

## Verification
On every cycle, the assertions check three things: that a cleared enable sends the state machine to IDLE, that a running phase counter never exceeds its shadowed length, and that the shadowed high and low counts hold still in the middle of a phase. They also check that the finite-repeat budget never reaches zero while a period is in flight, and that register writes land only at mapped addresses. The cycle-exact shape of each waveform can only be shown by the bench scenarios, which compare every output on every cycle against a model built from the requirements. These scenarios cover the lead-in delay, the number of repeated periods, the period boundary at which a new timing word takes over, the abandoned period after a disable, and the zero-count corners.

// File: rtl/pwm_lead_pkg.sv
package pwm_lead_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int LEAD_W = 15;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_HIGH,
        S_LOW,
        S_DONE
    } chan_state_e;
endpackage

// File: rtl/pwm_lead_regs.sv
module pwm_lead_regs
    import pwm_lead_pkg::*;
#(
    parameter int NCH     = 6,
    parameter int AW      = 4,
    parameter int HL_BASE = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [AW-1:0]                 addr,
    input  logic                          wr_en,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [DATA_W-1:0]             rd_data,
    output logic [NCH-1:0][DATA_W-1:0]    ctrl_o,
    output logic [NCH-1:0][DATA_W-1:0]    time_o
);
    logic [NCH-1:0][DATA_W-1:0] ctrl_q;
    logic [NCH-1:0][DATA_W-1:0] time_q;
    logic                       mapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            time_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NCH; i++) begin
                if (addr == AW'(i))           ctrl_q[i] <= wr_data;
                if (addr == AW'(HL_BASE + i)) time_q[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        mapped  = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == AW'(i)) begin
                rd_data = ctrl_q[i];
                mapped  = 1'b1;
            end
            if (addr == AW'(HL_BASE + i)) begin
                rd_data = time_q[i];
                mapped  = 1'b1;
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign time_o = time_q;

    // R2: an unmapped write leaves every register untouched
    a_r2_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mapped) |=> ($stable(ctrl_q) && $stable(time_q)));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R11: a mapped write is visible in the next cycle
        a_r11_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == AW'(g)) |=> (ctrl_q[g] == $past(wr_data)));
        a_r11_time_write: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == AW'(HL_BASE + g)) |=> (time_q[g] == $past(wr_data)));
    end
endmodule

// File: rtl/pwm_lead_chan.sv
module pwm_lead_chan
    import pwm_lead_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [LEAD_W-1:0] lead_i,
    input  logic [CNT_W-1:0]  rep_i,
    input  logic [CNT_W-1:0]  hi_i,
    input  logic [CNT_W-1:0]  lo_i,
    output logic              pwm_o
);
    chan_state_e       st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CNT_W-1:0]  hi_sh, hi_d;
    logic [CNT_W-1:0]  lo_sh, lo_d;
    logic [CNT_W-1:0]  rem_q, rem_d;
    logic              inf_q, inf_d;
    logic              start;
    logic              period_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            hi_sh <= '0;
            lo_sh <= '0;
            rem_q <= '0;
            inf_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            hi_sh <= hi_d;
            lo_sh <= lo_d;
            rem_q <= rem_d;
            inf_q <= inf_d;
        end
    end

    always_comb begin
        st_d       = st_q;
        cnt_d      = cnt_q;
        hi_d       = hi_sh;
        lo_d       = lo_sh;
        rem_d      = rem_q;
        inf_d      = inf_q;
        start      = 1'b0;
        period_end = 1'b0;
        if (!en_i) begin
            st_d = S_IDLE;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    rem_d = rep_i;
                    inf_d = (rep_i == '0);
                    if (lead_i != '0) begin
                        st_d  = S_LEAD;
                        cnt_d = CNT_W'(lead_i) - 1'b1;
                    end else begin
                        start = 1'b1;
                    end
                end
                S_LEAD: begin
                    if (cnt_q == '0) start = 1'b1;
                    else             cnt_d = cnt_q - 1'b1;
                end
                S_HIGH: begin
                    if (cnt_q != '0) begin
                        cnt_d = cnt_q - 1'b1;
                    end else if (lo_sh != '0) begin
                        st_d  = S_LOW;
                        cnt_d = lo_sh - 1'b1;
                    end else begin
                        period_end = 1'b1;
                    end
                end
                S_LOW: begin
                    if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
                    else             period_end = 1'b1;
                end
                S_DONE: begin
                    st_d = S_DONE;
                end
            endcase
        end
        if (period_end) begin
            if (!inf_q && rem_q == CNT_W'(1)) begin
                st_d = S_DONE;
            end else begin
                start = 1'b1;
                if (!inf_q) rem_d = rem_q - 1'b1;
            end
        end
        if (start) begin
            hi_d = hi_i;
            lo_d = lo_i;
            if (hi_i != '0) begin
                st_d  = S_HIGH;
                cnt_d = hi_i - 1'b1;
            end else begin
                st_d  = S_LOW;
                cnt_d = (lo_i != '0) ? lo_i - 1'b1 : '0;
            end
        end
    end

    always_comb begin
        pwm_o = en_i && (st_q == S_HIGH);
    end

    // R8: a cleared enable returns the machine to IDLE on the next edge
    a_r8_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st_q == S_IDLE));
    // R4: the high-phase counter stays below the shadowed high count
    a_r4_high_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_HIGH) |-> (cnt_q < hi_sh));
    // R9: shadowed counts hold while a phase is still counting down
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (st_q == S_HIGH || st_q == S_LOW) && cnt_q != '0)
        |=> ($stable(hi_sh) && $stable(lo_sh)));
    // R7: a finite run never has an exhausted budget during a period
    a_r7_budget_live: assert property (@(posedge clk) disable iff (!rst_n)
        (!inf_q && (st_q == S_HIGH || st_q == S_LOW)) |-> (rem_q != '0));
endmodule

// File: rtl/pwm_leadin_ctrl.sv
module pwm_leadin_ctrl
    import pwm_lead_pkg::*;
#(
    parameter int NCH     = 6,
    parameter int AW      = 4,
    parameter int HL_BASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCH-1:0]    pwm_out
);
    localparam int EN_BIT   = DATA_W - 1;
    localparam int LEAD_LSB = CNT_W;
    localparam int HI_LSB   = CNT_W;

    logic [NCH-1:0][DATA_W-1:0] ctrl;
    logic [NCH-1:0][DATA_W-1:0] timing;

    pwm_lead_regs #(.NCH(NCH), .AW(AW), .HL_BASE(HL_BASE)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .ctrl_o  (ctrl),
        .time_o  (timing)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_lead_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (ctrl[g][EN_BIT]),
            .lead_i (ctrl[g][LEAD_LSB +: LEAD_W]),
            .rep_i  (ctrl[g][CNT_W-1:0]),
            .hi_i   (timing[g][HI_LSB +: CNT_W]),
            .lo_i   (timing[g][CNT_W-1:0]),
            .pwm_o  (pwm_out[g])
        );
    end
endmodule

// File: tb/tb_pwm_leadin_ctrl.sv
module tb_pwm_leadin_ctrl;
    localparam int CLK_P = 10;
    localparam int NOCH  = 1 << 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [5:0]  pwm_out;

    pwm_leadin_ctrl dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    always #(CLK_P/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bench-side register image and per-channel waveform model state
    logic [31:0] ctrl_m [6];
    logic [31:0] time_m [6];
    int    mode [6];       // 0 none, 1 waveform model, 2 must be low
    int    st_e [6];
    int    m_l  [6];
    int    m_r  [6];
    int    m_h0 [6];
    int    m_l0 [6];
    int    m_w  [6];
    int    m_h1 [6];
    int    m_l1 [6];
    string tag  [6];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // expected output t cycles after the edge that enabled the channel
    function automatic bit exp_out(int t, int l, int rep, int h0, int l0, int w, int h1, int l1);
        int s, k, h, lw, p;
        if (t <= l) return 1'b0;
        s = 1 + l;
        k = 0;
        while (1) begin
            h  = (s > w) ? h1 : h0;
            lw = (s > w) ? l1 : l0;
            p  = (h + lw == 0) ? 1 : h + lw;
            if (rep != 0 && k >= rep) return 1'b0;
            if (t < s + p) return ((t - s) < h);
            s = s + p;
            k++;
        end
        return 1'b0;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 6; c++) begin
                if (mode[c] == 1) begin
                    bit e;
                    e = exp_out(cyc - st_e[c], m_l[c], m_r[c], m_h0[c], m_l0[c],
                                m_w[c], m_h1[c], m_l1[c]);
                    chk(pwm_out[c] == e, tag[c], longint'(pwm_out[c]), longint'(e));
                end else if (mode[c] == 2) begin
                    chk(pwm_out[c] == 1'b0, "R8 low after disable", longint'(pwm_out[c]), 0);
                end
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d, input string t);
        int c;
        @(negedge clk);
        addr = 4'(a); wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (a < 6) begin
            c = a;
            if (d[31] && !ctrl_m[c][31]) begin
                mode[c] = 1; st_e[c] = cyc; tag[c] = t;
                m_l[c] = int'(d[30:16]); m_r[c] = int'(d[15:0]);
                m_h0[c] = int'(time_m[c][31:16]); m_l0[c] = int'(time_m[c][15:0]);
                m_w[c] = NOCH; m_h1[c] = 0; m_l1[c] = 0;
            end else if (!d[31]) begin
                mode[c] = 2;
            end
            ctrl_m[c] = d;
        end else if (a >= 8 && a < 14) begin
            c = a - 8;
            time_m[c] = d;
            if (mode[c] == 1 && m_w[c] == NOCH) begin
                m_w[c] = cyc - st_e[c];
                m_h1[c] = int'(d[31:16]); m_l1[c] = int'(d[15:0]);
            end
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = 4'(a);
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] cw(bit en, int l, int r);
        return {en, 15'(l), 16'(r)};
    endfunction

    function automatic logic [31:0] tw(int h, int l);
        return {16'(h), 16'(l)};
    endfunction

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int c = 0; c < 6; c++) begin
            ctrl_m[c] = '0; time_m[c] = '0; mode[c] = 0; tag[c] = "";
            m_w[c] = NOCH;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state; R2: unmapped reads zero
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            chk(v == 32'h0, "R11 reset register value", longint'(v), 0);
        end
        chk(pwm_out == 6'h0, "R11 reset outputs low", longint'(pwm_out), 0);

        // R3 R11: readback of every mapped register (enable kept clear)
        for (int c = 0; c < 6; c++) begin
            wr(c, $urandom() & 32'h7fff_ffff, "R3");
            wr(8 + c, $urandom(), "R4");
        end
        wr(6, 32'hdead_beef, "R2");
        wr(15, 32'h1234_5678, "R2");
        wr(7, 32'hffff_ffff, "R2");
        wr(14, 32'h0f0f_0f0f, "R2");
        for (int a = 0; a < 16; a++) begin
            logic [31:0] e;
            rd(a, v);
            if (a < 6) e = ctrl_m[a];
            else if (a >= 8 && a < 14) e = time_m[a - 8];
            else e = 32'h0;
            chk(v == e, (a < 6 || (a >= 8 && a < 14)) ? "R3 R11 readback" : "R2 unmapped",
                longint'(v), longint'(e));
        end

        // R5 R4 R6: lead-in 3, high 2, low 3, endless
        wr(8, tw(2, 3), "R4");
        wr(0, cw(1, 3, 0), "R5 R4 R6 lead-in and endless periods");
        idle(40);

        // R7 R10: finite repeats and zero-count corners on other channels
        wr(9,  tw(1, 1), "R7");
        wr(10, tw(0, 4), "R10");
        wr(11, tw(5, 0), "R10");
        wr(12, tw(0, 0), "R10");
        wr(13, tw(3, 2), "R7");
        wr(1, cw(1, 0, 3), "R7 three periods then low");
        wr(2, cw(1, 1, 2), "R10 zero high count");
        wr(3, cw(1, 0, 0), "R10 zero low count steady high");
        wr(4, cw(1, 2, 0), "R10 both zero stays low");
        wr(5, cw(1, 2, 1), "R7 single period");
        idle(50);
        rd(1, v);
        chk(v[31] == 1'b1, "R7 enable still reads set after run", longint'(v[31]), 1);
        rd(5, v);
        chk(v[31] == 1'b1, "R7 enable still reads set after run", longint'(v[31]), 1);
        chk(pwm_out[1] == 1'b0 && pwm_out[5] == 1'b0, "R7 parked low",
            longint'(pwm_out), 0);
        wr(1, cw(1, 0, 3), "R7 rewrite while parked has no restart");
        idle(10);

        // R9: new timing mid-period, applied at the next boundary
        wr(0, cw(0, 0, 0), "R8");
        wr(8, tw(3, 2), "R9");
        wr(0, cw(1, 0, 0), "R9 new timing at next boundary");
        idle(2);
        wr(8, tw(1, 4), "R9");
        idle(30);

        // R8: disable in the middle of a high phase, then restart with lead-in
        wr(0, cw(0, 0, 0), "R8");
        wr(8, tw(6, 6), "R8");
        wr(0, cw(1, 0, 0), "R8 first run");
        idle(3);
        wr(0, cw(0, 0, 0), "R8");
        wr(0, cw(1, 2, 0), "R8 restart after abandoned period");
        idle(30);

        // R1: random independent configurations on all six channels
        for (int it = 0; it < 25; it++) begin
            for (int c = 0; c < 6; c++) wr(c, cw(0, 0, 0), "R8");
            for (int c = 0; c < 6; c++)
                wr(8 + c, tw($urandom_range(0, 6), $urandom_range(0, 6)), "R1");
            for (int c = 0; c < 6; c++)
                wr(c, cw(1, $urandom_range(0, 5), $urandom_range(0, 3)),
                   "R1 R9 random channel");
            idle($urandom_range(0, 20));
            if ($urandom_range(0, 1) == 1) begin
                int c;
                c = $urandom_range(0, 5);
                wr(8 + c, tw($urandom_range(0, 6), $urandom_range(0, 6)), "R9");
            end
            idle($urandom_range(40, 70));
        end

        finish_run();
    end
endmodule